// File: doc/BRIEF.md
# Open-Drain Channel Direction Arbiter

This block decides, cycle by cycle, which end of an open-drain bidirectional line is the talker. Each channel joins a host-side line and a card-side line. Both lines idle high on passive pull-ups. For each side the block reads the line level and drives a pull-low enable. Direction is not set by any control pin. Whichever line is seen falling first becomes the leading side. The block then pulls the opposite line low whenever the leader is low, so the follower copies it. This direction lock holds until both lines read high again, and then the channel returns to idle.

When the leader releases its line, the block stops pulling the follower low. On that same edge it starts a short active pull-up pulse on the follower side, which helps charge the stray capacitance of the rising edge. While the follower is being pulled, its own reading is ignored, so the echoed low cannot turn the direction around and latch the channel. The bank holds a parameterized number of identical channels: three by default, one for the data line and two for the auxiliary lines. Each channel has its own enable.

Top module: `odio_channel_bank`

## Requirements
- R1: While rst_n is low at a rising edge, every pull-low output and every boost output is 0 after that edge, and each channel is idle.
- R2: From idle, the side whose line is seen low first becomes the leader. While the leader's line is low, the follower's pull-low output is 1. The leader's own pull-low output stays 0, and the two pull-low outputs of a channel are never 1 together.
- R3: If both lines of an idle channel are first seen low in the same sample cycle, the host side becomes the leader.
- R4: A line change driven between rising edges reaches the follower's pull-low output on the (SYNC_STAGES+1)-th rising edge after it, and not earlier. With the default SYNC_STAGES=2 this is the third edge.
- R5: When the leader releases its line, the follower's pull-low output falls. On that same edge the follower's boost output rises and stays 1 for exactly BOOST_CYCLES cycles (default 4). The leader's boost output stays 0.
- R6: A boost output is never 1 together with the pull-low output of the same side. If the leader falls again during a pulse, the pulse is cut off on the edge where the pull-low output returns.
- R7: While a channel is locked, the follower's line level has no effect. The follower's pull-low output never asserts the leader's side, even when the follower line is held low from outside after the leader releases.
- R8: Once both lines read high, the channel returns to idle, and afterwards either side may lead.
- R9: When chan_en_i for a channel is 0 at a rising edge, both of its pull-low outputs and both of its boost outputs are 0 after that edge, and the channel is idle.
- R10: The channels are independent. Traffic on one channel leaves the outputs of the others unchanged.
- R11: A leader line toggling with 16-cycle low and high phases is followed on every phase, with the R4 latency on each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en_i | input | NUM_CH | Per-channel enable |
| host_line_i | input | NUM_CH | Host-side line level read back |
| card_line_i | input | NUM_CH | Card-side line level read back |
| host_pull_low_o | output | NUM_CH | Pull host line low |
| card_pull_low_o | output | NUM_CH | Pull card line low |
| host_boost_o | output | NUM_CH | Active pull-up pulse on host line |
| card_boost_o | output | NUM_CH | Active pull-up pulse on card line |

## Verification
Line levels pass through SYNC_STAGES sampling flops and then one output register. Each pull-low change and each pulse start is therefore due on the third rising edge after the stimulus, and an enable change takes effect on the first edge. The bench drives inputs on falling edges. It samples one falling edge before the due edge, expecting the old value, and again on the falling edge just after it, expecting the new value. Pulse length is measured by counting the falling edges on which the boost output is high. Between scenarios the bench waits long enough for the follower's echo to clear the sampling flops.

// File: rtl/odio_pkg.sv
// Shared types for the open-drain direction arbiter.
package odio_pkg;
    // Direction lock of one channel.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_HOST_LEADS = 2'd1,
        ST_CARD_LEADS = 2'd2
    } dir_state_t;
endpackage

// File: rtl/odio_line_sync.sv
// Samples one line level and outputs a "line is low" flag after STAGES flops.
// Assumes: the line may be asynchronous to clk; STAGES=0 bypasses sampling.
module odio_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic low_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign low_o = ~line_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the inverted line level through the sampling chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q[0] <= ~line_i;
                    for (int k = 1; k < STAGES; k++) begin
                        chain_q[k] <= chain_q[k-1];
                    end
                end
            end
            assign low_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/odio_boost_timer.sv
// Active pull-up pulse generator for one side of a channel.
// Assumes: load_i and cancel_i are never both set; cancel_i wins if they are.
module odio_boost_timer #(
    parameter int BOOST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic cancel_i,
    output logic boost_o
);
    localparam int CW = $clog2(BOOST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BOOST_CYCLES);

    logic [CW-1:0] cnt_q;

    // Load, cancel or count down the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cancel_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign boost_o = (cnt_q != '0);
endmodule

// File: rtl/odio_dir_fsm.sv
// Direction lock for one channel: first side seen low leads, host wins ties,
// lock released when both sampled lines read high. Pull-low outputs registered.
// Assumes: host_low_i/card_low_i are already sampled to clk.
module odio_dir_fsm
    import odio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic host_low_i,
    input  logic card_low_i,
    output logic host_pull_o,
    output logic card_pull_o,
    output logic host_pull_nxt_o,
    output logic card_pull_nxt_o,
    output logic host_rel_o,
    output logic card_rel_o
);
    dir_state_t state_q, state_nxt;

    // Next direction state from the sampled levels and enable.
    always_comb begin
        state_nxt = state_q;
        if (!en_i) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (host_low_i)      state_nxt = ST_HOST_LEADS;
                    else if (card_low_i) state_nxt = ST_CARD_LEADS;
                end
                ST_HOST_LEADS, ST_CARD_LEADS: begin
                    if (!host_low_i && !card_low_i) state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // Follower pull-low and leader-release events.
    always_comb begin
        card_pull_nxt_o = en_i && (state_nxt == ST_HOST_LEADS) && host_low_i;
        host_pull_nxt_o = en_i && (state_nxt == ST_CARD_LEADS) && card_low_i;
        card_rel_o      = en_i && (state_q == ST_HOST_LEADS) && card_pull_o && !host_low_i;
        host_rel_o      = en_i && (state_q == ST_CARD_LEADS) && host_pull_o && !card_low_i;
    end

    // Register state and pull-low enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            host_pull_o <= 1'b0;
            card_pull_o <= 1'b0;
        end else begin
            state_q     <= state_nxt;
            host_pull_o <= host_pull_nxt_o;
            card_pull_o <= card_pull_nxt_o;
        end
    end
endmodule

// File: rtl/odio_dir_arbiter.sv
// One channel: line sampling on both sides, direction lock, and one boost
// timer per side. Assumes: passive pull-ups hold idle lines high.
module odio_dir_arbiter #(
    parameter int SYNC_STAGES  = 2,
    parameter int BOOST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic host_line_i,
    input  logic card_line_i,
    output logic host_pull_low_o,
    output logic card_pull_low_o,
    output logic host_boost_o,
    output logic card_boost_o
);
    logic host_low, card_low;
    logic host_nxt, card_nxt, host_rel, card_rel;

    odio_line_sync #(.STAGES(SYNC_STAGES)) u_host_sync (
        .clk(clk), .rst_n(rst_n), .line_i(host_line_i), .low_o(host_low));
    odio_line_sync #(.STAGES(SYNC_STAGES)) u_card_sync (
        .clk(clk), .rst_n(rst_n), .line_i(card_line_i), .low_o(card_low));

    odio_dir_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .host_low_i(host_low), .card_low_i(card_low),
        .host_pull_o(host_pull_low_o), .card_pull_o(card_pull_low_o),
        .host_pull_nxt_o(host_nxt), .card_pull_nxt_o(card_nxt),
        .host_rel_o(host_rel), .card_rel_o(card_rel));

    odio_boost_timer #(.BOOST_CYCLES(BOOST_CYCLES)) u_host_boost (
        .clk(clk), .rst_n(rst_n), .load_i(host_rel),
        .cancel_i(!en_i || host_nxt), .boost_o(host_boost_o));
    odio_boost_timer #(.BOOST_CYCLES(BOOST_CYCLES)) u_card_boost (
        .clk(clk), .rst_n(rst_n), .load_i(card_rel),
        .cancel_i(!en_i || card_nxt), .boost_o(card_boost_o));
endmodule

// File: rtl/odio_channel_bank.sv
// Bank of NUM_CH independent open-drain direction arbiters (data + auxiliary).
// Assumes: one shared clock and reset; each channel has its own enable.
module odio_channel_bank #(
    parameter int NUM_CH       = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int BOOST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_en_i,
    input  logic [NUM_CH-1:0] host_line_i,
    input  logic [NUM_CH-1:0] card_line_i,
    output logic [NUM_CH-1:0] host_pull_low_o,
    output logic [NUM_CH-1:0] card_pull_low_o,
    output logic [NUM_CH-1:0] host_boost_o,
    output logic [NUM_CH-1:0] card_boost_o
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            odio_dir_arbiter #(
                .SYNC_STAGES(SYNC_STAGES),
                .BOOST_CYCLES(BOOST_CYCLES)
            ) u_arb (
                .clk(clk), .rst_n(rst_n), .en_i(chan_en_i[c]),
                .host_line_i(host_line_i[c]), .card_line_i(card_line_i[c]),
                .host_pull_low_o(host_pull_low_o[c]),
                .card_pull_low_o(card_pull_low_o[c]),
                .host_boost_o(host_boost_o[c]),
                .card_boost_o(card_boost_o[c]));
        end
    endgenerate
endmodule

// File: rtl/odio_channel_bank_chk.sv
// Property checker for odio_channel_bank, attached with bind.
module odio_channel_bank_chk #(
    parameter int NUM_CH       = 3,
    parameter int BOOST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_en_i,
    input logic [NUM_CH-1:0] host_pull_low_o,
    input logic [NUM_CH-1:0] card_pull_low_o,
    input logic [NUM_CH-1:0] host_boost_o,
    input logic [NUM_CH-1:0] card_boost_o
);
    localparam int RW = $clog2(BOOST_CYCLES + 2);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            logic [RW-1:0] run_q;
            // Length of the current card-side pulse, saturating.
            always_ff @(posedge clk) begin
                if (!rst_n)                     run_q <= '0;
                else if (!card_boost_o[c])      run_q <= '0;
                else if (run_q != RW'(BOOST_CYCLES + 1)) run_q <= run_q + 1'b1;
            end

            AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
                !(host_pull_low_o[c] && card_pull_low_o[c])); // R2
            AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !chan_en_i[c] |=> !(host_pull_low_o[c] || card_pull_low_o[c] ||
                                    host_boost_o[c] || card_boost_o[c])); // R9
            AST_CARD_BOOST_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
                !(card_boost_o[c] && card_pull_low_o[c])); // R6
            AST_HOST_BOOST_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
                !(host_boost_o[c] && host_pull_low_o[c])); // R6
            AST_BOOST_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(card_boost_o[c]) |-> $fell(card_pull_low_o[c])); // R5
            AST_BOOST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
                run_q <= RW'(BOOST_CYCLES)); // R5
        end
    endgenerate
endmodule

bind odio_channel_bank odio_channel_bank_chk #(
    .NUM_CH(NUM_CH),
    .BOOST_CYCLES(BOOST_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en_i),
    .host_pull_low_o(host_pull_low_o), .card_pull_low_o(card_pull_low_o),
    .host_boost_o(host_boost_o), .card_boost_o(card_boost_o));

// File: tb/tb_odio_channel_bank.sv
module tb_odio_channel_bank;
    localparam int N = 3;
    localparam int BOOST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] en = '1;
    logic [N-1:0] host_ext = '0;   // external agent pulling host line low
    logic [N-1:0] card_ext = '0;   // external agent pulling card line low
    logic [N-1:0] host_line, card_line;
    logic [N-1:0] host_pull_low_o, card_pull_low_o, host_boost_o, card_boost_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // Wired-AND open-drain lines with passive pull-ups.
    assign host_line = ~(host_ext | host_pull_low_o);
    assign card_line = ~(card_ext | card_pull_low_o);

    odio_channel_bank #(.NUM_CH(N), .SYNC_STAGES(2), .BOOST_CYCLES(BOOST)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en_i(en),
        .host_line_i(host_line), .card_line_i(card_line),
        .host_pull_low_o(host_pull_low_o), .card_pull_low_o(card_pull_low_o),
        .host_boost_o(host_boost_o), .card_boost_o(card_boost_o));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic fpull(input int ch, input bit host_leads);
        return host_leads ? card_pull_low_o[ch] : host_pull_low_o[ch];
    endfunction
    function automatic logic lpull(input int ch, input bit host_leads);
        return host_leads ? host_pull_low_o[ch] : card_pull_low_o[ch];
    endfunction
    function automatic logic fboost(input int ch, input bit host_leads);
        return host_leads ? card_boost_o[ch] : host_boost_o[ch];
    endfunction
    function automatic logic lboost(input int ch, input bit host_leads);
        return host_leads ? host_boost_o[ch] : card_boost_o[ch];
    endfunction

    task automatic set_ext(input int ch, input bit host_side, input logic v);
        if (host_side) host_ext[ch] = v; else card_ext[ch] = v;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        check("R1", "host_pull", |host_pull_low_o, 1'b0);
        check("R1", "card_pull", |card_pull_low_o, 1'b0);
        check("R1", "boosts", |(host_boost_o | card_boost_o), 1'b0);
        rst_n = 1'b1;
        step(4);
        check("R1", "idle after reset", |(host_pull_low_o | card_pull_low_o), 1'b0);
    endtask

    // One side leads a full low phase; checks latency, follow and pulse.
    task automatic t_lead(input int ch, input bit host_leads);
        int cnt;
        set_ext(ch, host_leads, 1'b1);
        step(2);
        check("R4", "follower early", fpull(ch, host_leads), 1'b0);
        step(1);
        check("R2", "follower pulled", fpull(ch, host_leads), 1'b1);
        check("R2", "leader not pulled", lpull(ch, host_leads), 1'b0);
        step(5);
        check("R2", "follower held", fpull(ch, host_leads), 1'b1);
        set_ext(ch, host_leads, 1'b0);
        step(2);
        check("R4", "release early", fpull(ch, host_leads), 1'b1);
        step(1);
        check("R5", "follower released", fpull(ch, host_leads), 1'b0);
        check("R5", "boost start", fboost(ch, host_leads), 1'b1);
        cnt = 1;
        for (int k = 0; k < BOOST + 2; k++) begin
            step(1);
            if (fboost(ch, host_leads)) cnt++;
            check("R5", "leader boost", lboost(ch, host_leads), 1'b0);
        end
        checks++;
        if (cnt != BOOST) begin
            errors++;
            $display("FAIL R5 pulse length: actual %0d expected %0d", cnt, BOOST);
        end
        step(8);
    endtask

    task automatic t_tie();
        host_ext[1] = 1'b1; card_ext[1] = 1'b1;
        step(3);
        check("R3", "card pulled on tie", card_pull_low_o[1], 1'b1);
        check("R3", "host free on tie", host_pull_low_o[1], 1'b0);
        host_ext[1] = 1'b0;
        step(3);
        check("R7", "card released", card_pull_low_o[1], 1'b0);
        for (int k = 0; k < 8; k++) begin
            step(1);
            check("R7", "card low ignored", host_pull_low_o[1], 1'b0);
        end
        card_ext[1] = 1'b0;
        step(8);
        card_ext[1] = 1'b1;
        step(3);
        check("R8", "card leads after idle", host_pull_low_o[1], 1'b1);
        card_ext[1] = 1'b0;
        step(12);
    endtask

    task automatic t_recut();
        host_ext[0] = 1'b1;
        step(5);
        host_ext[0] = 1'b0;
        step(1);
        host_ext[0] = 1'b1;
        step(2);
        check("R6", "pull dropped", card_pull_low_o[0], 1'b0);
        check("R6", "boost started", card_boost_o[0], 1'b1);
        step(1);
        check("R6", "pull back", card_pull_low_o[0], 1'b1);
        check("R6", "boost cut", card_boost_o[0], 1'b0);
        host_ext[0] = 1'b0;
        step(14);
    endtask

    task automatic t_disable();
        host_ext[2] = 1'b1;
        step(4);
        check("R9", "pulled before disable", card_pull_low_o[2], 1'b1);
        en[2] = 1'b0;
        step(1);
        check("R9", "pull off on disable", card_pull_low_o[2], 1'b0);
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R9", "stays off", card_pull_low_o[2] | host_pull_low_o[2], 1'b0);
            check("R9", "no boost", card_boost_o[2] | host_boost_o[2], 1'b0);
        end
        host_ext[2] = 1'b0;
        step(6);
        en[2] = 1'b1;
        step(6);
        check("R9", "idle after enable", card_pull_low_o[2] | host_pull_low_o[2], 1'b0);
    endtask

    task automatic t_indep();
        host_ext[0] = 1'b1; card_ext[1] = 1'b1;
        step(3);
        check("R10", "ch0 card pulled", card_pull_low_o[0], 1'b1);
        check("R10", "ch0 host free", host_pull_low_o[0], 1'b0);
        check("R10", "ch1 host pulled", host_pull_low_o[1], 1'b1);
        check("R10", "ch1 card free", card_pull_low_o[1], 1'b0);
        check("R10", "ch2 quiet", host_pull_low_o[2] | card_pull_low_o[2], 1'b0);
        host_ext[0] = 1'b0; card_ext[1] = 1'b0;
        step(14);
    endtask

    task automatic t_toggle();
        for (int k = 0; k < 4; k++) begin
            host_ext[0] = 1'b1;
            step(3);
            check("R11", "follow low phase", card_pull_low_o[0], 1'b1);
            step(13);
            host_ext[0] = 1'b0;
            step(3);
            check("R11", "follow high phase", card_pull_low_o[0], 1'b0);
            step(13);
        end
    endtask

    initial begin
        step(1);
        t_reset();
        t_lead(0, 1'b1);
        t_lead(2, 1'b0);
        t_tie();
        t_recut();
        t_disable();
        t_indep();
        t_toggle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule